// File: doc/BRIEF.md
# Programmable-Length Multi-Mode Timer Counter

This block is the main count register of a general-purpose timer. A single-cycle `tick` pulse from an upstream prescaler advances it. A two-bit mode input selects how it moves: hold, count up to a period and restart, count freely, or count up to the period and back down to zero. The period comes from the compare value of channel 0 of the timer. Software can load the count directly or clear it. A sticky wrap flag marks each wrap point.

A two-bit length select sets the effective width of the counter to 16, 12, 10 or 8 bits, and it may change at run time. Every increment, decrement, software load and period comparison is cut to the selected width. Because of this, one counter can serve both a fixed 16-bit timer and a variable-length one.

Top module: `prog_len_counter`

## Requirements
- R1: `len_sel` picks the effective width: 2'b00 is 16 bits, 2'b01 is 12 bits, 2'b10 is 10 bits, 2'b11 is 8 bits. Every update of the count (step or load) leaves no bit set above the selected width.
- R2: When `wr_en` is high and `clr` is low, the count takes `wr_data` ANDed with the width mask on the next edge. The load wins over a `tick` in the same cycle.
- R3: With mode 2'b00, or with `tick` low, the count and the direction do not change.
- R4: In mode 2'b01, a tick at count equal to the masked period returns the count to 0 and sets the wrap flag. Any other tick adds one, within the width mask.
- R5: In mode 2'b10, a tick adds one within the width mask. The wrap flag is set on the tick whose result is 0.
- R6: In mode 2'b11, the counter reverses to counting down on the tick where the count is at or above the masked period, and counts up again on the tick where the count is 0. A down step that reaches 0 sets the wrap flag. `count_down` is 1 while the direction is down.
- R7: `clr` high sets the count to 0 and the direction to up on the next edge. It takes priority over a load and a tick, and it leaves the wrap flag alone.
- R8: The wrap flag `wrap_flag` stays set until `wrap_ack` is pulsed. A new wrap in the same cycle as `wrap_ack` keeps it set.
- R9: The period compare in modes 2'b01 and 2'b11 uses `period` ANDed with the width mask.
- R10: After reset, the count is 0, the direction is up and the wrap flag is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse from the prescaler |
| mode | input | 2 | 00 hold, 01 up to period, 10 free run, 11 up/down |
| len_sel | input | 2 | Effective width: 00=16, 01=12, 10=10, 11=8 bits |
| period | input | CNT_W | Period value (channel 0 compare) |
| clr | input | 1 | Clear count and direction |
| wr_en | input | 1 | Load the count from `wr_data` |
| wr_data | input | CNT_W | Load value |
| wrap_ack | input | 1 | Clear the wrap flag |
| count | output | CNT_W | Current count |
| count_down | output | 1 | Direction, 1 = counting down |
| wrap_flag | output | 1 | Sticky wrap flag |

## Verification
A wrong width mask shows on the first step or load after the length changes: bits above the selected width appear on `count`, or a free-running wrap fires late. A stale direction register shows as a wrong `count` value within one tick of the period or of zero in up/down mode, and `count_down` exposes it directly. A lost or spurious wrap flag is visible one cycle after the wrapping tick, because the flag is registered alongside the count.

// File: rtl/prog_len_counter_pkg.sv
package prog_len_counter_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_FREE = 2'b10,
        MODE_UPDN = 2'b11
    } cnt_mode_e;

    localparam int NUM_LEN = 4;

    // Width reduction for each length select code
    function automatic int len_cut(input int code);
        case (code)
            1:       return 4;
            2:       return 6;
            3:       return 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/prog_len_counter_mask.sv
module prog_len_counter_mask #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       len_sel,
    output logic [CNT_W-1:0] mask
);
    import prog_len_counter_pkg::*;

    logic [CNT_W-1:0] mask_tab [NUM_LEN];

    for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
        localparam int BITS = CNT_W - len_cut(g);
        assign mask_tab[g] = {{(CNT_W-BITS){1'b0}}, {BITS{1'b1}}};
    end

    assign mask = mask_tab[len_sel];
endmodule

// File: rtl/prog_len_counter_step.sv
module prog_len_counter_step #(
    parameter int CNT_W = 16
) (
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             down,
    input  logic [CNT_W-1:0] period_m,
    input  logic [CNT_W-1:0] mask,
    output logic [CNT_W-1:0] nxt,
    output logic             nxt_down,
    output logic             wrap
);
    import prog_len_counter_pkg::*;

    logic [CNT_W-1:0] inc_m;
    logic [CNT_W-1:0] dec_m;
    logic             dir;

    assign inc_m = (cnt + 1'b1) & mask;
    assign dec_m = (cnt - 1'b1) & mask;

    always_comb begin
        nxt      = cnt;
        nxt_down = down;
        wrap     = 1'b0;
        dir      = down;
        case (cnt_mode_e'(mode))
            MODE_HOLD: begin
            end
            MODE_UP: begin
                if (cnt == period_m) begin
                    nxt      = '0;
                    wrap     = 1'b1;
                    nxt_down = 1'b0;
                end else begin
                    nxt = inc_m;
                end
            end
            MODE_FREE: begin
                nxt  = inc_m;
                wrap = (inc_m == '0);
            end
            MODE_UPDN: begin
                if (cnt >= period_m) dir = 1'b1;
                if (cnt == '0)       dir = 1'b0;
                nxt_down = dir;
                if (dir) begin
                    nxt  = dec_m;
                    wrap = (dec_m == '0);
                end else begin
                    nxt = inc_m;
                end
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/prog_len_counter.sv
module prog_len_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       mode,
    input  logic [1:0]       len_sel,
    input  logic [CNT_W-1:0] period,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wrap_ack,
    output logic [CNT_W-1:0] count,
    output logic             count_down,
    output logic             wrap_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             flag;
    } state_t;

    state_t           st_d, st_q;
    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] step_nxt;
    logic             step_down;
    logic             step_wrap;

    prog_len_counter_mask #(.CNT_W(CNT_W)) u_mask (
        .len_sel (len_sel),
        .mask    (mask)
    );

    prog_len_counter_step #(.CNT_W(CNT_W)) u_step (
        .mode     (mode),
        .cnt      (st_q.cnt),
        .down     (st_q.down),
        .period_m (period & mask),
        .mask     (mask),
        .nxt      (step_nxt),
        .nxt_down (step_down),
        .wrap     (step_wrap)
    );

    always_comb begin
        st_d = st_q;
        if (wrap_ack) st_d.flag = 1'b0;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (wr_en) begin
            st_d.cnt = wr_data & mask;
        end else if (tick) begin
            st_d.cnt  = step_nxt;
            st_d.down = step_down;
            if (step_wrap) st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count      = st_q.cnt;
    assign count_down = st_q.down;
    assign wrap_flag  = st_q.flag;
endmodule

// File: rtl/prog_len_counter_chk.sv
module prog_len_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       mode,
    input logic [1:0]       len_sel,
    input logic [CNT_W-1:0] period,
    input logic             clr,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             wrap_ack,
    input logic [CNT_W-1:0] count,
    input logic             count_down,
    input logic             wrap_flag
);
    logic [CNT_W-1:0] lim;
    always_comb begin
        case (len_sel)
            2'b01:   lim = {CNT_W{1'b1}} >> 4;
            2'b10:   lim = {CNT_W{1'b1}} >> 6;
            2'b11:   lim = {CNT_W{1'b1}} >> 8;
            default: lim = {CNT_W{1'b1}};
        endcase
    end

    logic step_ok;
    assign step_ok = tick && !clr && !wr_en;

    // R1
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && (wr_en || tick)) |=> ((count & ~$past(lim)) == '0));

    // R7
    clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0 && !count_down));

    // R3
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en && (!tick || mode == 2'b00)) |=>
            (count == $past(count) && count_down == $past(count_down)));

    // R5
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && mode == 2'b10) |=>
            (count == (($past(count) + 1'b1) & $past(lim))));

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wrap_flag) |-> $past(step_ok && mode != 2'b00));

    // R8
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_flag && !wrap_ack) |=> wrap_flag);
endmodule

bind prog_len_counter prog_len_counter_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_prog_len_counter.sv
module sim_prog_len_counter;
    localparam int CLK_NS = 10;
    localparam int W = 16;

    typedef struct packed {
        logic         clr;
        logic         wr;
        logic [15:0]  wd;
        logic [1:0]   md;
        logic [1:0]   ln;
        logic [15:0]  per;
        logic         tk;
        logic         ack;
        logic [15:0]  e_cnt;
        logic         e_flag;
        logic [23:0]  tag;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b1,16'h12FF,2'd2,2'd3,16'd0,1'b0,1'b0,16'h00FF,1'b0,"R2"}, // R2 load masked 8b
        '{1'b0,1'b0,16'h0000,2'd2,2'd3,16'd0,1'b1,1'b0,16'h0000,1'b1,"R5"}, // R5 wrap 8b
        '{1'b0,1'b0,16'h0000,2'd2,2'd3,16'd0,1'b1,1'b0,16'h0001,1'b1,"R5"}, // R5 then 1, flag kept
        '{1'b0,1'b0,16'h0000,2'd2,2'd3,16'd0,1'b0,1'b1,16'h0001,1'b0,"R8"}, // R8 ack
        '{1'b0,1'b1,16'hFFFF,2'd2,2'd2,16'd0,1'b0,1'b0,16'h03FF,1'b0,"R1"}, // R1 10b load
        '{1'b0,1'b0,16'h0000,2'd2,2'd2,16'd0,1'b1,1'b0,16'h0000,1'b1,"R5"}, // R5 10b wrap
        '{1'b0,1'b1,16'hFFFF,2'd2,2'd1,16'd0,1'b0,1'b1,16'h0FFF,1'b0,"R1"}, // R1 12b load
        '{1'b0,1'b0,16'h0000,2'd0,2'd1,16'd0,1'b1,1'b0,16'h0FFF,1'b0,"R3"}, // R3 hold mode
        '{1'b0,1'b0,16'h0000,2'd2,2'd0,16'd0,1'b1,1'b0,16'h1000,1'b0,"R1"}, // R1 16b no wrap
        '{1'b0,1'b1,16'hFFFF,2'd2,2'd0,16'd0,1'b0,1'b0,16'hFFFF,1'b0,"R2"}, // R2
        '{1'b0,1'b0,16'h0000,2'd2,2'd0,16'd0,1'b1,1'b0,16'h0000,1'b1,"R5"}, // R5 16b wrap
        '{1'b0,1'b0,16'h0000,2'd1,2'd0,16'd3,1'b1,1'b1,16'h0001,1'b0,"R4"}, // R4
        '{1'b0,1'b0,16'h0000,2'd1,2'd0,16'd3,1'b1,1'b0,16'h0002,1'b0,"R4"},
        '{1'b0,1'b0,16'h0000,2'd1,2'd0,16'd3,1'b1,1'b0,16'h0003,1'b0,"R4"},
        '{1'b0,1'b0,16'h0000,2'd1,2'd0,16'd3,1'b1,1'b0,16'h0000,1'b1,"R4"}, // R4 period hit
        '{1'b0,1'b1,16'h0055,2'd2,2'd0,16'd3,1'b1,1'b0,16'h0055,1'b1,"R2"}, // R2 load beats tick
        '{1'b0,1'b0,16'h0000,2'd2,2'd0,16'd3,1'b0,1'b0,16'h0055,1'b1,"R3"}  // R3 no tick
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic [1:0]     mode = 2'd0;
    logic [1:0]     len_sel = 2'd0;
    logic [W-1:0]   period = '0;
    logic           clr = 1'b0;
    logic           wr_en = 1'b0;
    logic [W-1:0]   wr_data = '0;
    logic           wrap_ack = 1'b0;
    logic [W-1:0]   count;
    logic           count_down;
    logic           wrap_flag;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    prog_len_counter #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .len_sel(len_sel),
        .period(period), .clr(clr), .wr_en(wr_en), .wr_data(wr_data),
        .wrap_ack(wrap_ack), .count(count), .count_down(count_down),
        .wrap_flag(wrap_flag)
    );

    task automatic check(input string tag, input logic [W-1:0] e_cnt,
                         input logic e_dn, input logic e_flag);
        n_run++;
        if (count !== e_cnt || count_down !== e_dn || wrap_flag !== e_flag) begin
            n_fail++;
            $display("FAIL %s: cnt=%h dn=%b flag=%b expected cnt=%h dn=%b flag=%b",
                     tag, count, count_down, wrap_flag, e_cnt, e_dn, e_flag);
        end
    endtask

    // drive on the falling edge, one rising edge, sample on the next falling edge
    task automatic cyc(input logic c, input logic w, input logic [W-1:0] d,
                       input logic [1:0] m, input logic [1:0] l,
                       input logic [W-1:0] p, input logic t, input logic a);
        clr = c; wr_en = w; wr_data = d; mode = m; len_sel = l;
        period = p; tick = t; wrap_ack = a;
        @(negedge clk);
        clr = 1'b0; wr_en = 1'b0; tick = 1'b0; wrap_ack = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R10", '0, 1'b0, 1'b0);          // R10 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cyc(TBL[i].clr, TBL[i].wr, TBL[i].wd, TBL[i].md, TBL[i].ln,
                TBL[i].per, TBL[i].tk, TBL[i].ack);
            check(string'(TBL[i].tag), TBL[i].e_cnt, 1'b0, TBL[i].e_flag);
        end

        // R7 clear wins over load and tick, flag untouched
        cyc(1'b1, 1'b1, 16'h0077, 2'd2, 2'd0, 16'd3, 1'b1, 1'b0);
        check("R7", 16'h0000, 1'b0, 1'b1);

        // R6 up/down with period 2, 8-bit
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        check("R6", 16'd1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        check("R6", 16'd2, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        check("R6", 16'd1, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        check("R6", 16'd0, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        check("R6", 16'd1, 1'b0, 1'b1);

        // R8 wrap together with ack keeps the flag
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b1);
        check("R8", 16'd0, 1'b1, 1'b1);

        // R7 clear while counting down resets direction
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b1);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        check("R6", 16'd1, 1'b1, 1'b0);
        cyc(1'b1, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b0, 1'b0);
        check("R7", 16'd0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd3, 2'd3, 16'd2, 1'b1, 1'b0);
        check("R7", 16'd1, 1'b0, 1'b0);

        // R9 period masked to 8 bits: 0x105 acts as 5
        cyc(1'b1, 1'b0, '0, 2'd1, 2'd3, 16'h0105, 1'b0, 1'b0);
        for (int k = 0; k < 5; k++)
            cyc(1'b0, 1'b0, '0, 2'd1, 2'd3, 16'h0105, 1'b1, 1'b0);
        check("R9", 16'd5, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, '0, 2'd1, 2'd3, 16'h0105, 1'b1, 1'b0);
        check("R9", 16'd0, 1'b0, 1'b1);

        // R1 8-bit free run across a full turn
        cyc(1'b1, 1'b0, '0, 2'd2, 2'd3, '0, 1'b0, 1'b1);
        for (int k = 0; k < 256; k++)
            cyc(1'b0, 1'b0, '0, 2'd2, 2'd3, '0, 1'b1, 1'b0);
        check("R1", 16'd0, 1'b0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule